// File: doc/BRIEF.md
# Key-Protected Strap Control Register Bank

This block is a small bank of control registers on a plain 32-bit memory-mapped bus. It holds a hardware-strap word that is captured from a set of strap pins while reset is asserted. Software can change that word only after it has opened the bank by writing a fixed 32-bit key to the protection register.

Once the bank is open, software changes the strap word through two addresses. One address sets every bit that is written as one. A second address, an alias of the first, clears every bit that is written as one. Zero bits written to either address have no effect. A write of any other value to the protection register closes the bank again. The block decodes a few strap bits into dedicated outputs for the clock and reset logic that follows it.

Each bus request completes in exactly one cycle. The ready strobe and the read data appear in the cycle after the request.

Top module: `strap_ctrl_bank`

## Requirements
- R1: A request (`req_i` high) raises `ready_o` for exactly the next cycle, and `rdata_o` is valid in that cycle. With no request, `ready_o` is low in the next cycle.
- R2: Writing 0x1688A8A8 to offset 0x00 opens the bank. A later read of offset 0x00 returns 0x00000001.
- R3: Writing any other value to offset 0x00 closes the bank. A read of offset 0x00 returns 0x00000000 while the bank is closed.
- R4: While the bank is open, a write to offset 0x70 sets each strap bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: While the bank is open, a write to offset 0x7C clears each strap bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: While the bank is closed, writes to offsets 0x70 and 0x7C leave the strap word unchanged.
- R7: Reads of offsets 0x70 and 0x7C both return the strap word. Any other offset reads as zero, and a write to it changes neither the strap word nor the lock state.
- R8: While `rst_ni` is low, the bank is closed and the strap word equals `strap_pins_i`.
- R9: `clk25_sel_o` equals strap bit 23. `usb48_sel_o` is high only when strap bits 23 and 18 are both 1. `fast_rst_o` equals strap bit 27.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_pins_i | input | 32 | Strap pin levels, captured during reset |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | Write (1) or read (0) |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with `ready_o` |
| ready_o | output | 1 | Transfer complete, one cycle after the request |
| strap_o | output | 32 | Current strap word |
| clk25_sel_o | output | 1 | Decoded 25 MHz input clock select |
| usb48_sel_o | output | 1 | Decoded 48 MHz USB clock select |
| fast_rst_o | output | 1 | Decoded fast-reset status flag |

## Verification
The hardest cases to reach from the ports are the ones that test protection after the bank has been opened and then closed again. A locked write to the set or clear alias must leave the strap word untouched. A near-miss key, one bit away from the real key, must close the bank rather than leave it open. The stimulus table therefore first opens the bank and then changes straps through both aliases. Next it writes the key with its lowest bit flipped, and then writes all ones to the clear alias, which would wipe every strap bit if protection had failed. A second reset with different pin levels then checks that the strap word is loaded from the pins again.

// File: rtl/strap_bank_pkg.sv
package strap_bank_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PROT = 2'd1,
    SEL_SET  = 2'd2,
    SEL_CLR  = 2'd3
  } sel_e;

  localparam logic [7:0]  OFS_PROT   = 8'h00;
  localparam logic [7:0]  OFS_SET    = 8'h70;
  localparam logic [7:0]  OFS_CLR    = 8'h7C;
  localparam logic [31:0] UNLOCK_KEY = 32'h1688_A8A8;
endpackage

// File: rtl/strap_addr_dec.sv
module strap_addr_dec
  import strap_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o
);
  always_comb begin
    if (addr_i == ADDR_W'(OFS_PROT))     sel_o = SEL_PROT;
    else if (addr_i == ADDR_W'(OFS_SET)) sel_o = SEL_SET;
    else if (addr_i == ADDR_W'(OFS_CLR)) sel_o = SEL_CLR;
    else                                 sel_o = SEL_NONE;
  end
endmodule

// File: rtl/strap_lock_ctrl.sv
module strap_lock_ctrl #(
  parameter int unsigned       DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY    = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prot_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              unlocked_o
);
  logic unlocked_q;

  // any non-key value re-locks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        unlocked_q <= 1'b0;
    else if (prot_wr_i) unlocked_q <= (wdata_i == KEY);
  end

  assign unlocked_o = unlocked_q;
endmodule

// File: rtl/strap_reg.sv
module strap_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] pins_i,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] strap_o
);
  logic [DATA_W-1:0] strap_q;
  logic [DATA_W-1:0] strap_d;

  always_comb begin
    strap_d = strap_q;
    if (set_i)      strap_d = strap_q | wdata_i;
    else if (clr_i) strap_d = strap_q & ~wdata_i;
  end

  // pins sampled while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strap_q <= pins_i;
    else         strap_q <= strap_d;
  end

  assign strap_o = strap_q;
endmodule

// File: rtl/strap_ctrl_bank.sv
module strap_ctrl_bank
  import strap_bank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CLK25_BIT = 23,
  parameter int unsigned USB48_BIT = 18,
  parameter int unsigned FRST_BIT  = 27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] strap_pins_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] strap_o,
  output logic              clk25_sel_o,
  output logic              usb48_sel_o,
  output logic              fast_rst_o
);
  localparam logic [DATA_W-1:0] KEY_W = DATA_W'(UNLOCK_KEY);

  sel_e              sel;
  logic              wr;
  logic              unlocked;
  logic [DATA_W-1:0] strap;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              ready_q;

  assign wr = req_i & we_i;

  strap_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  strap_lock_ctrl #(.DATA_W(DATA_W), .KEY(KEY_W)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .prot_wr_i  (wr && sel == SEL_PROT),
    .wdata_i    (wdata_i),
    .unlocked_o (unlocked)
  );

  strap_reg #(.DATA_W(DATA_W)) u_strap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pins_i  (strap_pins_i),
    .set_i   (wr && unlocked && sel == SEL_SET),
    .clr_i   (wr && unlocked && sel == SEL_CLR),
    .wdata_i (wdata_i),
    .strap_o (strap)
  );

  always_comb begin
    unique case (sel)
      SEL_PROT:         rd_mux = DATA_W'(unlocked);
      SEL_SET, SEL_CLR: rd_mux = strap;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= req_i;
      if (req_i && !we_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o     = rdata_q;
  assign ready_o     = ready_q;
  assign strap_o     = strap;
  assign clk25_sel_o = strap[CLK25_BIT];
  assign usb48_sel_o = strap[CLK25_BIT] & strap[USB48_BIT];
  assign fast_rst_o  = strap[FRST_BIT];
endmodule

// File: rtl/strap_ctrl_bank_chk.sv
module strap_ctrl_bank_chk
  import strap_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              ready_o,
  input logic [DATA_W-1:0] strap_o,
  input logic              unlocked
);
  logic wr_prot, wr_set, wr_clr;
  assign wr_prot = req_i && we_i && addr_i == ADDR_W'(OFS_PROT);
  assign wr_set  = req_i && we_i && addr_i == ADDR_W'(OFS_SET);
  assign wr_clr  = req_i && we_i && addr_i == ADDR_W'(OFS_CLR);

  // R1
  ready_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ready_o);
  // R1
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ready_o);
  // R2
  key_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_prot && wdata_i == DATA_W'(UNLOCK_KEY)) |=> unlocked);
  // R3
  bad_key_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_prot && wdata_i != DATA_W'(UNLOCK_KEY)) |=> !unlocked);
  // R4
  set_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked && wr_set) |=> ((strap_o & $past(wdata_i)) == $past(wdata_i)));
  // R5
  clr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked && wr_clr) |=> ((strap_o & $past(wdata_i)) == '0));
  // R6
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked && (wr_set || wr_clr)) |=> $stable(strap_o));
  // R7
  no_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_set || wr_clr) |=> $stable(strap_o));
endmodule

bind strap_ctrl_bank strap_ctrl_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .ready_o  (ready_o),
  .strap_o  (strap_o),
  .unlocked (unlocked)
);

// File: tb/strap_ctrl_bank_tb.sv
module strap_ctrl_bank_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] strap_pins_i = 32'h0880_1234;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o, strap_o;
  logic        ready_o, clk25_sel_o, usb48_sel_o, fast_rst_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  strap_ctrl_bank u_dut (.*);

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;  // write data or expected read data
    logic [7:0]  rq;    // requirement number
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 32'h0000_0000, 8'd8},  // R8 locked out of reset
    '{1'b0, 8'h70, 32'h0880_1234, 8'd8},  // R8 pins captured
    '{1'b1, 8'h70, 32'h0004_0000, 8'd6},
    '{1'b0, 8'h70, 32'h0880_1234, 8'd6},  // R6 locked set ignored
    '{1'b1, 8'h00, 32'h1688_A8A8, 8'd2},
    '{1'b0, 8'h00, 32'h0000_0001, 8'd2},  // R2 open reads 1
    '{1'b1, 8'h70, 32'h0004_0000, 8'd4},
    '{1'b0, 8'h70, 32'h0884_1234, 8'd4},  // R4 set bit 18
    '{1'b1, 8'h7C, 32'h0800_0000, 8'd5},
    '{1'b0, 8'h7C, 32'h0084_1234, 8'd5},  // R5 clear bit 27, R7 alias read
    '{1'b1, 8'h7C, 32'h0000_0000, 8'd5},
    '{1'b0, 8'h70, 32'h0084_1234, 8'd5},  // R5 zeros keep
    '{1'b1, 8'h70, 32'h0000_0000, 8'd4},
    '{1'b0, 8'h70, 32'h0084_1234, 8'd4},  // R4 zeros keep
    '{1'b1, 8'h00, 32'h1688_A8A9, 8'd3},
    '{1'b0, 8'h00, 32'h0000_0000, 8'd3},  // R3 near key closes
    '{1'b1, 8'h7C, 32'hFFFF_FFFF, 8'd6},
    '{1'b0, 8'h70, 32'h0084_1234, 8'd6},  // R6 locked clear ignored
    '{1'b0, 8'h40, 32'h0000_0000, 8'd7}   // R7 unmapped reads zero
  };

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = wr; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R8", {31'b0, ready_o}, 32'h0);
    check("R8", strap_o, 32'h0880_1234);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      bus(VEC[i].wr, VEC[i].addr, VEC[i].wr ? VEC[i].data : 32'h0);
      check("R1", {31'b0, ready_o}, 32'h1);
      if (!VEC[i].wr) check($sformatf("R%0d", VEC[i].rq), rdata_o, VEC[i].data);
    end

    // R1: ready drops after one idle cycle
    @(negedge clk_i);
    check("R1", {31'b0, ready_o}, 32'h0);

    // R9: strap now 0x0084_1234
    check("R9", {29'b0, clk25_sel_o, usb48_sel_o, fast_rst_o}, 32'b110);

    // R7: unmapped write while open changes nothing
    bus(1'b1, 8'h00, 32'h1688_A8A8);
    bus(1'b1, 8'h40, 32'hFFFF_FFFF);
    bus(1'b1, 8'h74, 32'hFFFF_FFFF);
    check("R7", strap_o, 32'h0084_1234);
    bus(1'b0, 8'h00, 32'h0);
    check("R7", rdata_o, 32'h1);

    // R9: bit 18 without bit 23 gives no 48 MHz select
    bus(1'b1, 8'h7C, 32'h0080_0000);
    bus(1'b1, 8'h70, 32'h0800_0000);
    check("R9", {29'b0, clk25_sel_o, usb48_sel_o, fast_rst_o}, 32'b001);

    // R8: second reset reloads from new pins and locks
    strap_pins_i = 32'h0004_0000;
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R8", strap_o, 32'h0004_0000);
    rst_ni = 1'b1;
    bus(1'b0, 8'h00, 32'h0);
    check("R8", rdata_o, 32'h0);
    bus(1'b1, 8'h70, 32'h0080_0000);
    check("R6", strap_o, 32'h0004_0000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule